// File: doc/BRIEF.md
# Three-Channel Waveform PWM Timer

This block is a PWM timer with one up-counter and three compare channels. Each channel drives one pin, and an external RC filter turns each pin into an analog signal. The counter runs from zero up to a programmable period value and then starts again at zero, so one PWM window lasts `period + 1` clock cycles. Each pin goes high when the counter reaches the period value and low when it reaches the channel's compare value. In every window, a pin is therefore high for a number of counts equal to its compare value.

The hardware advances the compare values itself at each window boundary:

- The sine channel takes the next sample from a 32-entry table.
- The ramp channel adds a programmed step and returns to zero once it would pass a programmed limit.
- The DC channel keeps a fixed duty.

The period and the DC compare value are double-buffered, so a write never produces a cut pulse in the middle of a window. A wrap strobe marks the last cycle of each window. A global enable stops the timer and restarts both sequences from their first entry.

Top module: `pwm_wavegen`

## Requirements
- R1: While enabled, the counter steps 0, 1, ..., P and then returns to 0, where P is the active period. `wrapPulse` is high for exactly one cycle per window, so consecutive wrap pulses are P+1 cycles apart.
- R2: In each window, each PWM pin is high for exactly C cycles, where C is that channel's compare value in effect for the window and 0 < C <= P.
- R3: A compare value of 0 keeps the pin low for the whole window. A compare value greater than P keeps it high for all P+1 cycles.
- R4: In window k after enable, the sine compare value is round(128 + 127*sin(2*pi*(k mod 32)/32)). The samples are 8-bit, and after entry 31 the sequence returns to entry 0.
- R5: The ramp compare value is 0 in the first window after enable. At each wrap, the step is added. If the sum would exceed the limit, the value returns to 0 instead.
- R6: The DC pin has the same compare value in every window until a new value is written.
- R7: A write to the period or DC register while running changes nothing in the current window. The new value applies from the window that starts at the next wrap.
- R8: While `enable` is low:
  - the counter is held at 0;
  - all three pins and `wrapPulse` are low;
  - shadow values load into the active registers directly.
  After enable rises, the sine sequence starts at entry 0 and the ramp starts at 0.
- R9: After reset, all outputs are low. The reset values are period 255, DC 0, ramp step 1 and ramp limit 255.
- R10: When `cfgWrEn` is high at a clock edge, `cfgData` is written to the register selected by `cfgAddr`: 0 = period, 1 = DC compare, 2 = ramp step, 3 = ramp limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds the timer idle |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | CNT_W | Configuration write data |
| pwmSine | output | 1 | Sine channel PWM pin |
| pwmRamp | output | 1 | Ramp channel PWM pin |
| pwmDc | output | 1 | DC channel PWM pin |
| wrapPulse | output | 1 | High on the last cycle of each window |

## Verification
The bench counts high cycles per window on each pin and compares the counts with a model. The model computes the sine samples with floating-point trigonometry and keeps its own ramp accumulator.

Random short periods with DC values drawn around and above the period test the clamping against the exact duty. They also make the ramp wrap often under varied step and limit values. One long run at period 255 leaves the sine samples unclamped, so every table entry and its ordering is distinguished.

Further directed cases cover:
- DC compare values of 0 and P+1;
- a write in the middle of a window, which separates double-buffered loading from an immediate load;
- a disable and re-enable in the middle of a run, which shows whether both sequences restart.

// File: rtl/pwm_wavegen_pkg.sv
package pwm_wavegen_pkg;

  typedef struct packed {
    logic wrap;   // last count of the window, timer running
    logic hold;   // timer idle
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ADDR_PERIOD = 2'd0,
    ADDR_DC     = 2'd1,
    ADDR_STEP   = 2'd2,
    ADDR_LIMIT  = 2'd3
  } cfg_addr_e;

  localparam int SINE_LEN   = 32;
  localparam int SINE_PTR_W = $clog2(SINE_LEN);

  // quarter-wave samples of 128 + 127*sin, index 0..8
  function automatic logic [7:0] quarterSample(input int q);
    case (q)
      0: quarterSample = 8'd128;
      1: quarterSample = 8'd153;
      2: quarterSample = 8'd177;
      3: quarterSample = 8'd199;
      4: quarterSample = 8'd218;
      5: quarterSample = 8'd234;
      6: quarterSample = 8'd245;
      7: quarterSample = 8'd253;
      default: quarterSample = 8'd255;
    endcase
  endfunction

  // full 32-entry table from quarter-wave symmetry
  function automatic logic [7:0] sineSample(input logic [SINE_PTR_W-1:0] idx);
    int k;
    k = int'(idx);
    if (k <= 8)       sineSample = quarterSample(k);
    else if (k <= 16) sineSample = quarterSample(16 - k);
    else if (k <= 24) sineSample = 8'(9'd256 - 9'(quarterSample(k - 16)));
    else              sineSample = 8'(9'd256 - 9'(quarterSample(32 - k)));
  endfunction

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] activePeriod,
  output logic [CNT_W-1:0] cnt,
  output ctrl_strobe_t     stb
);

  logic atTop;
  assign atTop = (cnt == activePeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (atTop)   cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  always_comb begin
    stb.wrap = enable && atTop;
    stb.hold = !enable;
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_CH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      stb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgData,
  output logic [CNT_W-1:0]  activePeriod,
  output logic [CNT_W-1:0]  activeDc,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              wrapPulse
);

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};
  localparam int CH_SINE = 0;
  localparam int CH_RAMP = 1;
  localparam int CH_DC   = 2;

  logic [CNT_W-1:0]      shPeriod, shDc, rampStep, rampLimit;
  logic [CNT_W-1:0]      activeSine, activeRamp;
  logic [SINE_PTR_W-1:0] sinePtr, sinePtrNext;
  logic [CNT_W:0]        rampSum;
  logic [CNT_W-1:0]      rampNext;
  logic [CNT_W-1:0]      chanCmp [NUM_CH];

  assign sinePtrNext = sinePtr + 1'b1;
  assign rampSum     = {1'b0, activeRamp} + {1'b0, rampStep};
  assign rampNext    = (rampSum > {1'b0, rampLimit}) ? '0 : rampSum[CNT_W-1:0];

  // shadow registers written through the configuration port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPeriod  <= MAX_VAL;
      shDc      <= '0;
      rampStep  <= CNT_W'(1);
      rampLimit <= MAX_VAL;
    end else if (cfgWrEn) begin
      case (cfg_addr_e'(cfgAddr))
        ADDR_PERIOD: shPeriod  <= cfgData;
        ADDR_DC:     shDc      <= cfgData;
        ADDR_STEP:   rampStep  <= cfgData;
        ADDR_LIMIT:  rampLimit <= cfgData;
        default:     ;
      endcase
    end
  end

  // active compare set, swapped only at the window boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePeriod <= MAX_VAL;
      activeDc     <= '0;
      activeSine   <= CNT_W'(sineSample('0));
      activeRamp   <= '0;
      sinePtr      <= '0;
    end else if (stb.hold) begin
      activePeriod <= shPeriod;
      activeDc     <= shDc;
      activeSine   <= CNT_W'(sineSample('0));
      activeRamp   <= '0;
      sinePtr      <= '0;
    end else if (stb.wrap) begin
      activePeriod <= shPeriod;
      activeDc     <= shDc;
      activeSine   <= CNT_W'(sineSample(sinePtrNext));
      activeRamp   <= rampNext;
      sinePtr      <= sinePtrNext;
    end
  end

  always_comb begin
    chanCmp[CH_SINE] = activeSine;
    chanCmp[CH_RAMP] = activeRamp;
    chanCmp[CH_DC]   = activeDc;
  end

  // high from the period match until the compare match
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwmOut[g] <= 1'b0;
      else       pwmOut[g] <= !stb.hold && (cnt < chanCmp[g]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrapPulse <= 1'b0;
    else       wrapPulse <= stb.wrap;
  end

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  output logic             pwmSine,
  output logic             pwmRamp,
  output logic             pwmDc,
  output logic             wrapPulse
);

  localparam int NUM_CH = 3;

  ctrl_strobe_t     stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] activeDc;
  logic [NUM_CH-1:0] pwmOut;

  pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .activePeriod (activePeriod),
    .cnt          (cnt),
    .stb          (stb)
  );

  pwm_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cnt          (cnt),
    .cfgWrEn      (cfgWrEn),
    .cfgAddr      (cfgAddr),
    .cfgData      (cfgData),
    .activePeriod (activePeriod),
    .activeDc     (activeDc),
    .pwmOut       (pwmOut),
    .wrapPulse    (wrapPulse)
  );

  assign pwmSine = pwmOut[0];
  assign pwmRamp = pwmOut[1];
  assign pwmDc   = pwmOut[2];

endmodule

// File: rtl/pwm_wavegen_chk.sv
module pwm_wavegen_chk
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] activePeriod,
  input logic [CNT_W-1:0] activeDc,
  input ctrl_strobe_t     stb,
  input logic             pwmSine,
  input logic             pwmRamp,
  input logic             pwmDc,
  input logic             wrapPulse
);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt == activePeriod) |=> (cnt == '0)); // R1

  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> ($past(cnt) == $past(activePeriod))); // R1

  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeDc == '0) |=> !pwmDc); // R3

  AST_OVER_CMP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && activeDc > activePeriod) |=> pwmDc); // R3

  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !stb.wrap) |=> $stable(activeDc) && $stable(activePeriod)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pwmSine && !pwmRamp && !pwmDc && !wrapPulse && cnt == '0)); // R8

endmodule

bind pwm_wavegen pwm_wavegen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm_wavegen_bench.sv
module pwm_wavegen_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [1:0]       cfgAddr = '0;
  logic [CNT_W-1:0] cfgData = '0;
  logic             pwmSine, pwmRamp, pwmDc, wrapPulse;

  int checks = 0;
  int fails  = 0;

  // model state
  int pendP = 255, pendDc = 0, curP = 255, curDc = 0;
  int step = 1, limit = 255, rampCur = 0, sineIdx = 0;
  int hiSine = 0, hiRamp = 0, hiDc = 0, lenAcc = 0;
  int winCount = 0;
  bit firstWin = 1'b1;

  always #2 clk = ~clk;

  pwm_wavegen #(.CNT_W(CNT_W)) u_pwm_wavegen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .pwmSine(pwmSine),
    .pwmRamp(pwmRamp), .pwmDc(pwmDc), .wrapPulse(wrapPulse)
  );

  function automatic int sineRef(input int k);
    real a;
    a = 2.0 * 3.14159265358979 * real'(k) / 32.0;
    return $rtoi(128.0 + 127.0 * $sin(a) + 0.5);
  endfunction

  function automatic int expHigh(input int cmp, input int p);
    return (cmp > p) ? p + 1 : cmp;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-window monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!enable) begin
        curP = pendP; curDc = pendDc; rampCur = 0; sineIdx = 0;
        hiSine = 0; hiRamp = 0; hiDc = 0; lenAcc = 0; firstWin = 1'b1;
      end else begin
        hiSine += int'(pwmSine); hiRamp += int'(pwmRamp); hiDc += int'(pwmDc);
        lenAcc++;
        if (wrapPulse) begin
          check("R4", "sine highs", hiSine, expHigh(sineRef(sineIdx), curP));
          check("R5", "ramp highs", hiRamp, expHigh(rampCur, curP));
          check("R2", "dc highs",   hiDc,   expHigh(curDc, curP));
          if (!firstWin) check("R1", "window length", lenAcc, curP + 1);
          firstWin = 1'b0;
          sineIdx = (sineIdx + 1) % 32;
          rampCur = (rampCur + step > limit) ? 0 : rampCur + step;
          curP = pendP; curDc = pendDc;
          hiSine = 0; hiRamp = 0; hiDc = 0; lenAcc = 0;
          winCount++;
        end
      end
    end
  end

  task automatic cfgWrite(input int addr, input int data);
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgAddr = 2'(addr); cfgData = CNT_W'(data);
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    case (addr)
      0: pendP  = data;
      1: pendDc = data;
      2: step   = data;
      default: limit = data;
    endcase
  endtask

  task automatic waitWindows(input int n);
    int target;
    target = winCount + n;
    while (winCount < target) @(negedge clk);
  endtask

  task automatic runConfig(input int p, input int dc, input int st, input int lim, input int n);
    @(posedge clk); #1; enable = 1'b0;
    cfgWrite(0, p); cfgWrite(1, dc); cfgWrite(2, st); cfgWrite(3, lim);
    repeat (3) @(posedge clk);
    #1; enable = 1'b1;
    waitWindows(n);
  endtask

  task automatic checkQuiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(req, "pins and wrap low",
            int'(pwmSine) + int'(pwmRamp) + int'(pwmDc) + int'(wrapPulse), 0);
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed, p, dc, st, lim;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkQuiet("R9", 4);            // reset state, outputs low
    checkQuiet("R8", 4);            // still disabled

    // R9 R4 R5: reset defaults (period 255, step 1) with full-width sine
    @(posedge clk); #1; enable = 1'b1;
    waitWindows(34);

    // R3: DC compare 0 and above the period
    runConfig(9, 0, 2, 7, 5);
    runConfig(9, 10, 3, 20, 5);
    runConfig(4, 255, 1, 3, 6);

    // R7: DC and period written mid-window take effect at the next wrap
    runConfig(20, 5, 1, 255, 2);
    @(negedge clk); while (!wrapPulse) @(negedge clk);
    cfgWrite(1, 12);
    cfgWrite(0, 14);
    waitWindows(4);

    // R8: disable mid-run holds everything low, restart resets sequences
    @(posedge clk); #1; enable = 1'b0;
    @(negedge clk);
    checkQuiet("R8", 10);
    @(posedge clk); #1; enable = 1'b1;
    waitWindows(6);

    // R2 R5 R6 R10: constrained random configurations
    for (int c = 0; c < 10; c++) begin
      p   = 3 + int'($urandom_range(37));
      dc  = int'($urandom_range(p + 5));
      st  = 1 + int'($urandom_range(8));
      lim = 5 + int'($urandom_range(55));
      runConfig(p, dc, st, lim, 20);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule